// File: doc/BRIEF.md
# MSI Directory Controller (Parent Side)

This block is the home node of a two-level MSI coherence scheme. It owns a small backing memory. For every address it keeps a directory row that holds, for each of two to four child caches, the MSI state the parent believes that child holds. The row also holds a per-child wait marker that names the level the parent has asked the child to fall to.

Children send two kinds of message into the block:

- upgrade requests, on a request channel that is held until it is accepted;
- downgrade responses, on a response channel that may be requested or voluntary and may carry dirty data.

The block handles one message per cycle. Responses always win over requests. Requests from different children are picked round-robin.

An upgrade is granted only when no wait is open on that address and every sibling's recorded state is compatible with the requested level. While a request cannot be granted, it stays at the head of its channel, and the block sends downgrade requests to the siblings in the way. Every outgoing message is placed on a registered per-child output lane.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every recorded child state is I (code 0) and no wait is open, no lane is valid and no ready is high. The first request for any address is granted at once, with data.
- R2: Two children may both be recorded as S (code 1) for one address. A request for S is granted while a sibling holds S.
- R3: A request for level y (S=1, M=2) is accepted, with its ready high in that cycle, only if no child has an open wait for the address and every sibling is compatible with y. Compatibility fails only for M against M and for M against S, in either order. In the next cycle the requester's lane is valid with kind 0 (upgrade response), level y and the request's address.
- R4: An upgrade response sets has_data and carries the current memory word only when the requester was recorded as I. Otherwise has_data is 0.
- R5: A request that cannot be granted is not accepted. Each sibling recorded above the target level and with no open wait gets a downgrade request (kind 1) in the next cycle, and an open wait is recorded for it. The target level is I (0) when y is M and S (1) when y is S. A sibling with an open wait gets no repeated request.
- R6: A downgrade response to level z writes its data into memory if the child was recorded as M. It then records z for that child and closes the child's wait if the awaited level is at or above z.
- R7: A downgrade response is accepted in the cycle it is offered. In a cycle with any response offered, no request is accepted and no downgrade requests are sent.
- R8: Requests are picked round-robin among children with a valid request, and only one message is consumed per cycle. With k children requesting grantable addresses, all k are accepted within k cycles.
- R9: No address is ever recorded as M for more than one child.
- R10: A voluntary downgrade response, sent with no request outstanding, is handled like a requested one. A later request from a sibling is then granted without any downgrade being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | N_CHILD | Upgrade request valid, one per child |
| up_addr_i | input | N_CHILD x ADDR_W | Upgrade request address per child |
| up_lvl_i | input | N_CHILD x 2 | Requested level per child (1=S, 2=M) |
| up_ready_o | output | N_CHILD | Upgrade request accepted this cycle |
| dn_valid_i | input | N_CHILD | Downgrade response valid, one per child |
| dn_addr_i | input | N_CHILD x ADDR_W | Downgrade response address per child |
| dn_lvl_i | input | N_CHILD x 2 | Level the child fell to (0=I, 1=S) |
| dn_data_i | input | N_CHILD x DATA_W | Dirty data carried by the response |
| dn_ready_o | output | N_CHILD | Downgrade response accepted this cycle |
| msg_valid_o | output | N_CHILD | Outgoing lane valid per child |
| msg_dnreq_o | output | N_CHILD | Lane kind: 0 upgrade response, 1 downgrade request |
| msg_addr_o | output | N_CHILD x ADDR_W | Lane address |
| msg_lvl_o | output | N_CHILD x 2 | Granted level or downgrade target |
| msg_has_data_o | output | N_CHILD | Upgrade response carries memory data |
| msg_data_o | output | N_CHILD x DATA_W | Memory data for the requester |
| ld_we_i | input | 1 | Memory load write enable |
| ld_addr_i | input | ADDR_W | Memory load address |
| ld_data_i | input | DATA_W | Memory load data |

## Verification
The following properties are checked on every cycle:

- the directory never records two M owners for one address;
- responses shut out requests;
- at most one message is consumed per cycle;
- every accepted request is followed by an upgrade response on its lane;
- a downgrade request never targets M.

Only the directed scenarios can show the rest:

- that the right siblings are downgraded, and to the right level;
- that waits suppress repeated requests and are closed by lower-level answers;
- that dirty data reaches memory and returns to the next requester;
- that a voluntary downgrade removes the need for any fan-out.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam logic [1:0] LV_I = 2'd0;
  localparam logic [1:0] LV_S = 2'd1;
  localparam logic [1:0] LV_M = 2'd2;

  function automatic logic st_compat(input logic [1:0] a, input logic [1:0] b);
    return !((a == LV_M && b != LV_I) || (b == LV_M && a != LV_I));
  endfunction

  // level a sibling must fall to so that a request for want can be granted
  function automatic logic [1:0] dn_target(input logic [1:0] want);
    return (want == LV_M) ? LV_I : LV_S;
  endfunction
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] cand;
  int            j;

  // lowest offset from ptr_q+1 wins; ptr_q itself is last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    cand  = '0;
    j     = 0;
    for (int k = N; k >= 1; k--) begin
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      cand = IW'(j);
      if (req_i[cand]) begin
        any_o = 1'b1;
        idx_o = cand;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= IW'(N - 1);
    else if (adv_i) ptr_q <= idx_o;
  end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int N  = 3,
  parameter int AW = 3,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [AW-1:0]                addr_i,
  output logic [N-1:0][1:0]            st_row_o,
  output logic [N-1:0]                 wv_row_o,
  output logic [N-1:0][1:0]            wl_row_o,
  input  logic                         st_we_i,
  input  logic [IW-1:0]                child_i,
  input  logic [1:0]                   st_val_i,
  input  logic [N-1:0]                 wt_set_i,
  input  logic [1:0]                   wt_lvl_i,
  input  logic                         wt_clr_i,
  output logic [DEPTH-1:0][N-1:0][1:0] st_all_o
);
  logic [N-1:0][1:0] st_q [DEPTH];
  logic [N-1:0]      wv_q [DEPTH];
  logic [N-1:0][1:0] wl_q [DEPTH];

  assign st_row_o = st_q[addr_i];
  assign wv_row_o = wv_q[addr_i];
  assign wl_row_o = wl_q[addr_i];

  always_comb begin
    for (int a = 0; a < DEPTH; a++) st_all_o[a] = st_q[a];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) begin
        st_q[a] <= '0;
        wv_q[a] <= '0;
        wl_q[a] <= '0;
      end
    end else begin
      if (st_we_i) st_q[addr_i][child_i] <= st_val_i;
      for (int i = 0; i < N; i++) begin
        if (wt_set_i[i]) begin
          wv_q[addr_i][i] <= 1'b1;
          wl_q[addr_i][i] <= wt_lvl_i;
        end
      end
      if (wt_clr_i) wv_q[addr_i][child_i] <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_data_mem.sv
module coh_data_mem #(
  parameter int AW = 3,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          ext_we_i,
  input  logic [AW-1:0] ext_addr_i,
  input  logic [DW-1:0] ext_data_i,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  // load port wins over write-back
  always_ff @(posedge clk_i) begin
    if (ext_we_i)     mem_q[ext_addr_i] <= ext_data_i;
    else if (wb_we_i) mem_q[wb_addr_i]  <= wb_data_i;
  end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_pkg::*;
#(
  parameter int N_CHILD = 3,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  localparam int CW    = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_CHILD-1:0]              up_valid_i,
  input  logic [N_CHILD-1:0][ADDR_W-1:0]  up_addr_i,
  input  logic [N_CHILD-1:0][1:0]         up_lvl_i,
  output logic [N_CHILD-1:0]              up_ready_o,
  input  logic [N_CHILD-1:0]              dn_valid_i,
  input  logic [N_CHILD-1:0][ADDR_W-1:0]  dn_addr_i,
  input  logic [N_CHILD-1:0][1:0]         dn_lvl_i,
  input  logic [N_CHILD-1:0][DATA_W-1:0]  dn_data_i,
  output logic [N_CHILD-1:0]              dn_ready_o,
  output logic [N_CHILD-1:0]              msg_valid_o,
  output logic [N_CHILD-1:0]              msg_dnreq_o,
  output logic [N_CHILD-1:0][ADDR_W-1:0]  msg_addr_o,
  output logic [N_CHILD-1:0][1:0]         msg_lvl_o,
  output logic [N_CHILD-1:0]              msg_has_data_o,
  output logic [N_CHILD-1:0][DATA_W-1:0]  msg_data_o,
  input  logic                            ld_we_i,
  input  logic [ADDR_W-1:0]               ld_addr_i,
  input  logic [DATA_W-1:0]               ld_data_i
);
  logic                     up_any, dn_any, up_go, grant;
  logic [CW-1:0]            up_idx, dn_idx, act_idx;
  logic [ADDR_W-1:0]        sel_addr;
  logic [1:0]               y_up, need, dn_lvl;
  logic [N_CHILD-1:0][1:0]  st_row, wl_row;
  logic [N_CHILD-1:0]       wv_row, dn_fan;
  logic                     compat, wait_any, wt_clr, wb_we;
  logic [DATA_W-1:0]        mem_rd;
  logic [DEPTH-1:0][N_CHILD-1:0][1:0] st_all;

  coh_rr_arb #(.N(N_CHILD)) u_up_arb (
    .clk_i, .rst_ni, .req_i(up_valid_i), .adv_i(up_go),
    .any_o(up_any), .idx_o(up_idx)
  );

  coh_rr_arb #(.N(N_CHILD)) u_dn_arb (
    .clk_i, .rst_ni, .req_i(dn_valid_i), .adv_i(dn_any),
    .any_o(dn_any), .idx_o(dn_idx)
  );

  assign up_go    = up_any && !dn_any;
  assign act_idx  = dn_any ? dn_idx : up_idx;
  assign sel_addr = dn_any ? dn_addr_i[dn_idx] : up_addr_i[up_idx];
  assign y_up     = up_lvl_i[up_idx];
  assign dn_lvl   = dn_lvl_i[dn_idx];
  assign need     = dn_target(y_up);

  coh_dir_table #(.N(N_CHILD), .AW(ADDR_W)) u_table (
    .clk_i, .rst_ni,
    .addr_i   (sel_addr),
    .st_row_o (st_row),
    .wv_row_o (wv_row),
    .wl_row_o (wl_row),
    .st_we_i  (grant || dn_any),
    .child_i  (act_idx),
    .st_val_i (dn_any ? dn_lvl : y_up),
    .wt_set_i (dn_fan),
    .wt_lvl_i (need),
    .wt_clr_i (wt_clr),
    .st_all_o (st_all)
  );

  coh_data_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk_i,
    .ext_we_i   (ld_we_i),
    .ext_addr_i (ld_addr_i),
    .ext_data_i (ld_data_i),
    .wb_we_i    (wb_we),
    .wb_addr_i  (sel_addr),
    .wb_data_i  (dn_data_i[dn_idx]),
    .rd_addr_i  (sel_addr),
    .rd_data_o  (mem_rd)
  );

  always_comb begin
    wait_any = |wv_row;
    compat   = 1'b1;
    for (int i = 0; i < N_CHILD; i++) begin
      if (CW'(i) != up_idx && !st_compat(st_row[i], y_up)) compat = 1'b0;
    end
  end

  assign grant = up_go && !wait_any && compat;

  always_comb begin
    for (int i = 0; i < N_CHILD; i++) begin
      dn_fan[i] = up_go && !grant && (CW'(i) != up_idx) &&
                  (st_row[i] > need) && !wv_row[i];
    end
  end

  assign wt_clr = dn_any && wv_row[dn_idx] && (wl_row[dn_idx] >= dn_lvl);
  assign wb_we  = dn_any && (st_row[dn_idx] == LV_M);

  assign up_ready_o = grant  ? (N_CHILD'(1) << up_idx) : '0;
  assign dn_ready_o = dn_any ? (N_CHILD'(1) << dn_idx) : '0;

  for (genvar c = 0; c < N_CHILD; c++) begin : g_lane
    logic own;
    assign own = grant && (up_idx == CW'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        msg_valid_o[c]    <= 1'b0;
        msg_dnreq_o[c]    <= 1'b0;
        msg_addr_o[c]     <= '0;
        msg_lvl_o[c]      <= '0;
        msg_has_data_o[c] <= 1'b0;
        msg_data_o[c]     <= '0;
      end else begin
        msg_valid_o[c]    <= own || dn_fan[c];
        msg_dnreq_o[c]    <= dn_fan[c];
        msg_addr_o[c]     <= sel_addr;
        msg_lvl_o[c]      <= dn_fan[c] ? need : y_up;
        msg_has_data_o[c] <= own && (st_row[c] == LV_I);
        msg_data_o[c]     <= (own && st_row[c] == LV_I) ? mem_rd : '0;
      end
    end
  end
endmodule

// File: rtl/coh_dir_ctrl_chk.sv
module coh_dir_ctrl_chk
  import coh_pkg::*;
#(
  parameter int N_CHILD = 3,
  parameter int ADDR_W  = 3,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [N_CHILD-1:0]                 up_valid_i,
  input logic [N_CHILD-1:0]                 up_ready_o,
  input logic [N_CHILD-1:0]                 dn_valid_i,
  input logic [N_CHILD-1:0]                 dn_ready_o,
  input logic [N_CHILD-1:0]                 msg_valid_o,
  input logic [N_CHILD-1:0]                 msg_dnreq_o,
  input logic [N_CHILD-1:0][1:0]            msg_lvl_o,
  input logic [DEPTH-1:0][N_CHILD-1:0][1:0] st_all_i
);
  logic multi_m;
  int   cnt;

  always_comb begin
    multi_m = 1'b0;
    cnt     = 0;
    for (int a = 0; a < DEPTH; a++) begin
      cnt = 0;
      for (int c = 0; c < N_CHILD; c++) if (st_all_i[a][c] == LV_M) cnt = cnt + 1;
      if (cnt > 1) multi_m = 1'b1;
    end
  end

  p_one_owner_r9: assert property (@(posedge clk_i) disable iff (!rst_ni) !multi_m);

  p_dn_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dn_valid_i) |-> (up_ready_o == '0));

  p_dn_taken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dn_valid_i) |-> ($countones(dn_ready_o) == 1));

  p_one_msg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_ready_o, dn_ready_o}));

  for (genvar c = 0; c < N_CHILD; c++) begin : g_chk
    p_ready_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_ready_o[c] |-> up_valid_i[c]);

    p_grant_reply_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_ready_o[c] |=> (msg_valid_o[c] && !msg_dnreq_o[c]));

    p_dn_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_valid_o[c] && msg_dnreq_o[c]) |-> (msg_lvl_o[c] != LV_M));
  end
endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(.N_CHILD(N_CHILD), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .up_valid_i  (up_valid_i),
  .up_ready_o  (up_ready_o),
  .dn_valid_i  (dn_valid_i),
  .dn_ready_o  (dn_ready_o),
  .msg_valid_o (msg_valid_o),
  .msg_dnreq_o (msg_dnreq_o),
  .msg_lvl_o   (msg_lvl_o),
  .st_all_i    (st_all)
);

// File: tb/coh_dir_ctrl_tb_top.sv
module coh_dir_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]          up_valid = '0;
  logic [N-1:0][AW-1:0]  up_addr  = '0;
  logic [N-1:0][1:0]     up_lvl   = '0;
  logic [N-1:0]          up_ready;
  logic [N-1:0]          dn_valid = '0;
  logic [N-1:0][AW-1:0]  dn_addr  = '0;
  logic [N-1:0][1:0]     dn_lvl   = '0;
  logic [N-1:0][DW-1:0]  dn_data  = '0;
  logic [N-1:0]          dn_ready;
  logic [N-1:0]          msg_valid, msg_dnreq, msg_has;
  logic [N-1:0][AW-1:0]  msg_addr;
  logic [N-1:0][1:0]     msg_lvl;
  logic [N-1:0][DW-1:0]  msg_data;
  logic                  ld_we = 1'b0;
  logic [AW-1:0]         ld_addr = '0;
  logic [DW-1:0]         ld_data = '0;

  logic [N-1:0] s_up, s_dn;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_dir_ctrl #(.N_CHILD(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni,
    .up_valid_i(up_valid), .up_addr_i(up_addr), .up_lvl_i(up_lvl), .up_ready_o(up_ready),
    .dn_valid_i(dn_valid), .dn_addr_i(dn_addr), .dn_lvl_i(dn_lvl), .dn_data_i(dn_data),
    .dn_ready_o(dn_ready),
    .msg_valid_o(msg_valid), .msg_dnreq_o(msg_dnreq), .msg_addr_o(msg_addr),
    .msg_lvl_o(msg_lvl), .msg_has_data_o(msg_has), .msg_data_o(msg_data),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // inputs are set at a negedge; readies sampled, edge taken, lanes visible after
  task automatic tick();
    #1;
    s_up = up_ready;
    s_dn = dn_ready;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    up_valid = '0;
    dn_valid = '0;
  endtask

  task automatic set_up(input int c, input int a, input int l);
    up_valid[c] = 1'b1;
    up_addr[c]  = AW'(a);
    up_lvl[c]   = 2'(l);
  endtask

  task automatic set_dn(input int c, input int a, input int l, input int d);
    dn_valid[c] = 1'b1;
    dn_addr[c]  = AW'(a);
    dn_lvl[c]   = 2'(l);
    dn_data[c]  = DW'(d);
  endtask

  task automatic lane(input string rq, input int c, input bit v, input bit dq, input int a,
                      input int l, input bit has, input int d);
    chk(rq, $sformatf("lane%0d valid", c), 32'(msg_valid[c]), 32'(v));
    if (v) begin
      chk(rq, $sformatf("lane%0d kind", c), 32'(msg_dnreq[c]), 32'(dq));
      chk(rq, $sformatf("lane%0d addr", c), 32'(msg_addr[c]), 32'(a));
      chk(rq, $sformatf("lane%0d lvl", c), 32'(msg_lvl[c]), 32'(l));
      if (!dq) chk(rq, $sformatf("lane%0d has_data", c), 32'(msg_has[c]), 32'(has));
      if (!dq && has) chk(rq, $sformatf("lane%0d data", c), 32'(msg_data[c]), 32'(d));
    end
  endtask

  // one request alone; expect a grant with given data flag
  task automatic req_grant(input string rq, input int c, input int a, input int l,
                           input bit has, input int d);
    set_up(c, a, l);
    tick();
    clr();
    chk(rq, "ready", 32'(s_up), 32'(1 << c));
    lane(rq, c, 1'b1, 1'b0, a, l, has, d);
  endtask

  task automatic dn_one(input string rq, input int c, input int a, input int l, input int d);
    set_dn(c, a, l, d);
    tick();
    clr();
    chk(rq, "dn ready", 32'(s_dn), 32'(1 << c));
    for (int k = 0; k < N; k++) lane(rq, k, 1'b0, 1'b0, 0, 0, 1'b0, 0);
  endtask

  task automatic t_reset();
    tick();
    chk("R1", "up_ready idle", 32'(s_up), 0);
    chk("R1", "dn_ready idle", 32'(s_dn), 0);
    chk("R1", "lanes idle", 32'(msg_valid), 0);
  endtask

  task automatic t_shared();
    req_grant("R1", 0, 1, 1, 1'b1, 'hA001);
    lane("R1", 1, 1'b0, 1'b0, 0, 0, 1'b0, 0);
    req_grant("R2", 1, 1, 1, 1'b1, 'hA001);
  endtask

  task automatic t_fanout();
    set_up(2, 1, 2);
    tick();
    clr();
    chk("R5", "blocked ready", 32'(s_up), 0);
    lane("R5", 0, 1'b1, 1'b1, 1, 0, 1'b0, 0);
    lane("R5", 1, 1'b1, 1'b1, 1, 0, 1'b0, 0);
    lane("R5", 2, 1'b0, 1'b0, 0, 0, 1'b0, 0);
    set_up(2, 1, 2);
    tick();
    clr();
    chk("R5", "retry ready", 32'(s_up), 0);
    chk("R5", "no repeat", 32'(msg_valid), 0);
    // response and request together: response wins
    set_up(2, 1, 2);
    set_dn(0, 1, 0, 'h0);
    tick();
    clr();
    chk("R7", "req held off", 32'(s_up), 0);
    chk("R7", "resp taken", 32'(s_dn), 1);
    chk("R7", "no lanes", 32'(msg_valid), 0);
    dn_one("R6", 1, 1, 0, 'h0);
    req_grant("R3", 2, 1, 2, 1'b1, 'hA001);
  endtask

  task automatic t_writeback();
    set_up(0, 1, 2);
    tick();
    clr();
    chk("R5", "blocked by M", 32'(s_up), 0);
    lane("R5", 2, 1'b1, 1'b1, 1, 0, 1'b0, 0);
    lane("R5", 1, 1'b0, 1'b0, 0, 0, 1'b0, 0);
    dn_one("R6", 2, 1, 0, 'hBEEF);
    req_grant("R6", 0, 1, 2, 1'b1, 'hBEEF);
  endtask

  task automatic t_nodata_and_to_s();
    req_grant("R4", 1, 2, 1, 1'b1, 'hA002);
    req_grant("R4", 1, 2, 2, 1'b0, 0);
    set_up(2, 2, 1);
    tick();
    clr();
    chk("R5", "load blocked", 32'(s_up), 0);
    lane("R5", 1, 1'b1, 1'b1, 2, 1, 1'b0, 0);
    lane("R5", 0, 1'b0, 1'b0, 0, 0, 1'b0, 0);
    dn_one("R6", 1, 2, 1, 'h1234);
    req_grant("R6", 2, 2, 1, 1'b1, 'h1234);
    set_up(0, 2, 2);
    tick();
    clr();
    lane("R5", 1, 1'b1, 1'b1, 2, 0, 1'b0, 0);
    lane("R5", 2, 1'b1, 1'b1, 2, 0, 1'b0, 0);
    dn_one("R6", 1, 2, 0, 'h0);
    dn_one("R6", 2, 2, 0, 'h0);
    req_grant("R3", 0, 2, 2, 1'b1, 'h1234);
  endtask

  task automatic t_lower_answer();
    req_grant("R3", 1, 4, 2, 1'b1, 'hA004);
    set_up(0, 4, 1);
    tick();
    clr();
    lane("R5", 1, 1'b1, 1'b1, 4, 1, 1'b0, 0);
    dn_one("R6", 1, 4, 0, 'h4444);
    req_grant("R6", 0, 4, 1, 1'b1, 'h4444);
    lane("R6", 1, 1'b0, 1'b0, 0, 0, 1'b0, 0);
  endtask

  task automatic t_voluntary();
    dn_one("R10", 0, 1, 0, 'h5555);
    req_grant("R10", 1, 1, 1, 1'b1, 'h5555);
    lane("R10", 0, 1'b0, 1'b0, 0, 0, 1'b0, 0);
    lane("R10", 2, 1'b0, 1'b0, 0, 0, 1'b0, 0);
  endtask

  task automatic t_fair();
    logic [N-1:0] done;
    done = '0;
    set_up(0, 5, 1);
    set_up(1, 6, 1);
    set_up(2, 7, 1);
    for (int k = 0; k < N; k++) begin
      tick();
      chk("R8", "one per cycle", 32'($countones(s_up)), 1);
      done = done | s_up;
      up_valid = up_valid & ~s_up;
    end
    clr();
    chk("R8", "all served", 32'(done), 32'((1 << N) - 1));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    for (int a = 0; a < (1 << AW); a++) begin
      ld_we   = 1'b1;
      ld_addr = AW'(a);
      ld_data = DW'('hA000 + a);
      @(negedge clk);
    end
    ld_we = 1'b0;
    t_shared();
    t_fanout();
    t_writeback();
    t_nodata_and_to_s();
    t_lower_answer();
    t_voluntary();
    t_fair();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule